// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register side of a serial port as a processor sees it. It holds a status register, a receive/transmit data register, a baud-rate register, three control registers and a guard-time register. All of them sit behind a plain word-addressed read/write bus in a 0x400-byte window. The block has one level interrupt output.

Received characters arrive on a byte-valid input with a ready handshake. The block keeps a single holding slot: while a received byte is still unread, ready stays low and the byte source waits. Writing the data register sends a byte out on a byte-valid output, which pulses for exactly one cycle. Serial bit timing, parity, framing and flow control belong to other blocks. The baud-rate, second and third control and guard-time registers are storage only.

Bus reads return data combinationally in the cycle the read strobe is high. Side effects of reads, writes and received bytes take effect at the next clock edge. When several events land in one cycle they are applied in this order: data read, status write, transmit write, control write, received byte.

Top module: `uart_regfront`

## Requirements
- R1: After reset the status register (offset 0x00) reads 0x000000C0, all other registers read 0, the interrupt is low and no transmit pulse is present.
- R2: The receive-ready output is low exactly while the receive-full flag (status bit 5) is set. A byte offered while it is low is not taken.
- R3: A byte taken while control register 1 (offset 0x0C) lacks either the port enable (bit 13) or the receive enable (bit 2) is dropped. Status and data stay unchanged.
- R4: A byte taken while both enables are set is stored in the data register (offset 0x04) and sets status bit 5. The interrupt goes high on the next cycle if control bit 5 (receive interrupt enable) is set.
- R5: A data-register read returns the stored byte in bits 9:0 with the upper bits zero. It clears status bit 5 and drops the interrupt on the next cycle.
- R6: A status write of 0x3FF or less loads the written value with bit 7 forced to 1. A larger value is ANDed into the current status.
- R7: After a status write that leaves bit 5 clear, the interrupt is low on the next cycle.
- R8: A data write below 0xF000 produces a one-cycle transmit pulse carrying the low byte on the next cycle and sets status bit 6. A data write of 0xF000 or more produces no pulse and leaves status unchanged.
- R9: A control-register-1 write with bit 5 set while status bit 5 is already set raises the interrupt on the next cycle.
- R10: The registers at 0x08, 0x10, 0x14 and 0x18 read back the last full 32-bit value written.
- R11: Reads of any other offset return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte offset in the register window |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe; read side effects apply at the next edge |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data, valid while busRdEn is high |
| rxValid | input | 1 | Received byte is offered |
| rxByte | input | BYTE_W | Received byte |
| rxReady | output | 1 | Block can take a received byte |
| txValid | output | 1 | One-cycle transmit pulse |
| txByte | output | BYTE_W | Transmitted byte |
| irq | output | 1 | Registered level interrupt |

## Verification
Received bytes are offered in four situations: with the port disabled, with only the port enabled, with both enables set, and while the slot is still full. These separate the dropped path, the stored path and back-pressure. Status writes use small values, a large masking value and a value that sets the receive flag, which distinguishes load from AND. Data writes just below and at the 0xF000 limit show whether the threshold is placed correctly. Interrupt cases come from a received byte with the enable set and from a late enable of an already full slot, so both raise paths are checked separately from the clear paths.

// File: rtl/uart_regfront_pkg.sv
`timescale 1ns/1ps
package uart_regfront_pkg;

  localparam int REG_W   = 32;
  localparam int STORE_N = 4;
  localparam int STORE_IW = $clog2(STORE_N);

  // Word offsets inside the window
  localparam logic [11:0] OFF_SR   = 12'h000;
  localparam logic [11:0] OFF_DR   = 12'h004;
  localparam logic [11:0] OFF_BRR  = 12'h008;
  localparam logic [11:0] OFF_CR1  = 12'h00C;
  localparam logic [11:0] OFF_CR2  = 12'h010;
  localparam logic [11:0] OFF_CR3  = 12'h014;
  localparam logic [11:0] OFF_GTPR = 12'h018;

  // Status bits
  localparam int RXNE_BIT = 5;
  localparam int TC_BIT   = 6;
  localparam int TXE_BIT  = 7;

  // Control register 1 bits
  localparam int RE_BIT   = 2;
  localparam int RXIE_BIT = 5;
  localparam int UE_BIT   = 13;

  localparam logic [REG_W-1:0] SR_RESET     = 32'h0000_00C0;
  localparam logic [REG_W-1:0] SR_LOAD_MAX  = 32'h0000_03FF;
  localparam logic [REG_W-1:0] DR_TX_LIMIT  = 32'h0000_F000;
  localparam logic [REG_W-1:0] DR_READ_MASK = 32'h0000_03FF;

  // Slots of the storage-only register bank
  localparam logic [STORE_IW-1:0] IDX_BRR  = 2'd0;
  localparam logic [STORE_IW-1:0] IDX_CR2  = 2'd1;
  localparam logic [STORE_IW-1:0] IDX_CR3  = 2'd2;
  localparam logic [STORE_IW-1:0] IDX_GTPR = 2'd3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SR,
    SEL_DR,
    SEL_CR1,
    SEL_STORE
  } regSel_e;

  typedef struct packed {
    logic                srWrite;
    logic                srLoad;
    logic                drRead;
    logic                txLaunch;
    logic                cr1Write;
    logic [STORE_N-1:0]  storeWrite;
    logic [STORE_IW-1:0] storeIdx;
    logic                rxTake;
    logic                rxStore;
    regSel_e             rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/uart_regfront_ctrl.sv
`timescale 1ns/1ps
module uart_regfront_ctrl
  import uart_regfront_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [REG_W-1:0]     busWData,
  input  logic                 rxValid,
  input  logic                 rxFull,
  input  logic                 enUart,
  input  logic                 enRx,
  output ctrlStrobe_t          strobe
);

  regSel_e             hitSel;
  logic [STORE_IW-1:0] hitIdx;

  // Address decode: only exact word offsets hit
  always_comb begin
    hitSel = SEL_NONE;
    hitIdx = '0;
    unique case (busAddr)
      ADDR_W'(OFF_SR):   hitSel = SEL_SR;
      ADDR_W'(OFF_DR):   hitSel = SEL_DR;
      ADDR_W'(OFF_CR1):  hitSel = SEL_CR1;
      ADDR_W'(OFF_BRR):  begin hitSel = SEL_STORE; hitIdx = IDX_BRR;  end
      ADDR_W'(OFF_CR2):  begin hitSel = SEL_STORE; hitIdx = IDX_CR2;  end
      ADDR_W'(OFF_CR3):  begin hitSel = SEL_STORE; hitIdx = IDX_CR3;  end
      ADDR_W'(OFF_GTPR): begin hitSel = SEL_STORE; hitIdx = IDX_GTPR; end
      default:           hitSel = SEL_NONE;
    endcase
  end

  logic [STORE_N-1:0] storeHit;

  for (genvar g = 0; g < STORE_N; g++) begin : g_storeDec
    assign storeHit[g] = (hitSel == SEL_STORE) && (hitIdx == STORE_IW'(g));
  end

  always_comb begin
    strobe            = '0;
    strobe.rdSel      = busRdEn ? hitSel : SEL_NONE;
    strobe.storeIdx   = hitIdx;
    strobe.drRead     = busRdEn && (hitSel == SEL_DR);
    strobe.srWrite    = busWrEn && (hitSel == SEL_SR);
    strobe.srLoad     = busWData <= SR_LOAD_MAX;
    strobe.txLaunch   = busWrEn && (hitSel == SEL_DR) && (busWData < DR_TX_LIMIT);
    strobe.cr1Write   = busWrEn && (hitSel == SEL_CR1);
    strobe.storeWrite = busWrEn ? storeHit : '0;
    strobe.rxTake     = rxValid && !rxFull;
    strobe.rxStore    = rxValid && !rxFull && enUart && enRx;
  end

endmodule

// File: rtl/uart_regfront_dp.sv
`timescale 1ns/1ps
module uart_regfront_dp
  import uart_regfront_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [REG_W-1:0]  busWData,
  input  logic [BYTE_W-1:0] rxByte,
  output logic [REG_W-1:0]  busRData,
  output logic              rxFull,
  output logic              enUart,
  output logic              enRx,
  output logic              txValid,
  output logic [BYTE_W-1:0] txByte,
  output logic              irq
);

  logic [REG_W-1:0]  srQ, srNext;
  logic [REG_W-1:0]  cr1Q, cr1Next;
  logic [BYTE_W-1:0] dataQ;
  logic              irqQ, irqNext;
  logic [REG_W-1:0]  storeQ [STORE_N];

  assign rxFull = srQ[RXNE_BIT];
  assign enUart = cr1Q[UE_BIT];
  assign enRx   = cr1Q[RE_BIT];
  assign irq    = irqQ;

  // Event ordering: read, status write, transmit, control write, receive
  always_comb begin
    srNext  = srQ;
    irqNext = irqQ;
    cr1Next = strobe.cr1Write ? busWData : cr1Q;
    if (strobe.drRead) begin
      srNext[RXNE_BIT] = 1'b0;
      irqNext          = 1'b0;
    end
    if (strobe.srWrite) begin
      if (strobe.srLoad) begin
        srNext          = busWData;
        srNext[TXE_BIT] = 1'b1;
      end else begin
        srNext = srNext & busWData;
      end
      if (!srNext[RXNE_BIT]) irqNext = 1'b0;
    end
    if (strobe.txLaunch) srNext[TC_BIT] = 1'b1;
    if (strobe.cr1Write && cr1Next[RXIE_BIT] && srNext[RXNE_BIT]) irqNext = 1'b1;
    if (strobe.rxStore) begin
      srNext[RXNE_BIT] = 1'b1;
      if (cr1Next[RXIE_BIT]) irqNext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srQ     <= SR_RESET;
      cr1Q    <= '0;
      dataQ   <= '0;
      irqQ    <= 1'b0;
      txValid <= 1'b0;
      txByte  <= '0;
    end else begin
      srQ     <= srNext;
      cr1Q    <= cr1Next;
      irqQ    <= irqNext;
      txValid <= strobe.txLaunch;
      if (strobe.txLaunch) txByte <= busWData[BYTE_W-1:0];
      if (strobe.rxStore)  dataQ  <= rxByte;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < STORE_N; i++) begin
      if (!rstN)                     storeQ[i] <= '0;
      else if (strobe.storeWrite[i]) storeQ[i] <= busWData;
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_SR:    busRData = srQ;
      SEL_DR:    busRData = REG_W'(dataQ) & DR_READ_MASK;
      SEL_CR1:   busRData = cr1Q;
      SEL_STORE: busRData = storeQ[strobe.storeIdx];
      default:   busRData = '0;
    endcase
  end

endmodule

// File: rtl/uart_regfront.sv
`timescale 1ns/1ps
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [REG_W-1:0]  busWData,
  output logic [REG_W-1:0]  busRData,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  output logic              rxReady,
  output logic              txValid,
  output logic [BYTE_W-1:0] txByte,
  output logic              irq
);

  ctrlStrobe_t strobe;
  logic        rxFull;
  logic        enUart;
  logic        enRx;

  assign rxReady = !rxFull;

  uart_regfront_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .busAddr  (busAddr),
    .busWData (busWData),
    .rxValid  (rxValid),
    .rxFull   (rxFull),
    .enUart   (enUart),
    .enRx     (enRx),
    .strobe   (strobe)
  );

  uart_regfront_dp #(.BYTE_W(BYTE_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWData (busWData),
    .rxByte   (rxByte),
    .busRData (busRData),
    .rxFull   (rxFull),
    .enUart   (enUart),
    .enRx     (enRx),
    .txValid  (txValid),
    .txByte   (txByte),
    .irq      (irq)
  );

endmodule

// File: rtl/uart_regfront_chk.sv
`timescale 1ns/1ps
module uart_regfront_chk
  import uart_regfront_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [REG_W-1:0]  busWData,
  input logic [REG_W-1:0]  busRData,
  input logic              rxValid,
  input logic              rxReady,
  input logic              txValid,
  input logic              irq
);

  logic wrDr, wrSr, wrCr1, rdDr, decoded;
  assign wrDr  = busWrEn && busAddr == ADDR_W'(OFF_DR);
  assign wrSr  = busWrEn && busAddr == ADDR_W'(OFF_SR);
  assign wrCr1 = busWrEn && busAddr == ADDR_W'(OFF_CR1);
  assign rdDr  = busRdEn && busAddr == ADDR_W'(OFF_DR);
  assign decoded = busAddr == ADDR_W'(OFF_SR)  || busAddr == ADDR_W'(OFF_DR)  ||
                   busAddr == ADDR_W'(OFF_BRR) || busAddr == ADDR_W'(OFF_CR1) ||
                   busAddr == ADDR_W'(OFF_CR2) || busAddr == ADDR_W'(OFF_CR3) ||
                   busAddr == ADDR_W'(OFF_GTPR);

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!rxReady && !busRdEn && !busWrEn) |=> !rxReady);

  p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past((rxValid && rxReady) || (wrCr1 && busWData[RXIE_BIT])));

  p_dr_read_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdDr && !busWrEn && !(rxValid && rxReady)) |=> (rxReady && !irq));

  p_sr_clear_irq_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrSr && busWData <= SR_LOAD_MAX && !busWData[RXNE_BIT] && !rxValid) |=> !irq);

  p_tx_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(wrDr && busWData < DR_TX_LIMIT));

  p_tx_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrDr && busWData >= DR_TX_LIMIT) |=> !txValid);

  p_undecoded_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !decoded) |-> busRData == '0);

endmodule

bind uart_regfront uart_regfront_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busRdEn  (busRdEn),
  .busWData (busWData),
  .busRData (busRData),
  .rxValid  (rxValid),
  .rxReady  (rxReady),
  .txValid  (txValid),
  .irq      (irq)
);

// File: tb/uart_regfront_tb_top.sv
`timescale 1ns/1ps
module uart_regfront_tb_top;

  localparam int ADDR_W = 10;
  localparam int BYTE_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic              busRdEn = 1'b0;
  logic [31:0]       busWData = '0;
  logic [31:0]       busRData;
  logic              rxValid = 1'b0;
  logic [BYTE_W-1:0] rxByte = '0;
  logic              rxReady;
  logic              txValid;
  logic [BYTE_W-1:0] txByte;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [BYTE_W-1:0] txExp[$];

  always #2.5 clk = ~clk;

  uart_regfront #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWData(busWData), .busRData(busRData),
    .rxValid(rxValid), .rxByte(rxByte), .rxReady(rxReady),
    .txValid(txValid), .txByte(txByte), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    busAddr = a; busWData = d; busWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRData;
    @(posedge clk); @(negedge clk);
    busRdEn = 1'b0;
  endtask

  // Driver for transmit: scoreboard gets the expected byte
  task automatic sendTx(input logic [31:0] d);
    if (d < 32'hF000) txExp.push_back(d[7:0]);
    busWrite(10'h004, d);
  endtask

  task automatic offerRx(input logic [7:0] b, input int cycles);
    rxByte = b; rxValid = 1'b1;
    repeat (cycles) begin @(posedge clk); @(negedge clk); end
    rxValid = 1'b0;
  endtask

  task automatic expectReg(input logic [ADDR_W-1:0] a, input logic [31:0] e,
                           input string req);
    logic [31:0] v;
    busRead(a, v);
    check(v === e, req, v, e);
  endtask

  // Monitor: every transmit pulse must match the head of the queue (R8)
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rstN && txValid) begin
        if (txExp.size() == 0) begin
          check(1'b0, "R8 unexpected tx", {24'h0, txByte}, 32'h0);
        end else begin
          logic [7:0] e;
          e = txExp.pop_front();
          check(txByte === e, "R8 tx byte", {24'h0, txByte}, {24'h0, e});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    check(irq === 1'b0, "R1 irq", {31'h0, irq}, 32'h0);
    check(txValid === 1'b0, "R1 txValid", {31'h0, txValid}, 32'h0);
    expectReg(10'h000, 32'h0000_00C0, "R1 status");
    expectReg(10'h004, 32'h0, "R1 data");
    expectReg(10'h00C, 32'h0, "R1 cr1");
    expectReg(10'h008, 32'h0, "R1 brr");
    expectReg(10'h018, 32'h0, "R1 gtpr");
    check(rxReady === 1'b1, "R2 ready after reset", {31'h0, rxReady}, 32'h1);

    // R3 drop while disabled, then with only port enable
    offerRx(8'h99, 1);
    expectReg(10'h000, 32'h0000_00C0, "R3 status disabled");
    expectReg(10'h004, 32'h0, "R3 data disabled");
    busWrite(10'h00C, 32'h0000_2000);
    offerRx(8'h98, 1);
    check(rxReady === 1'b1, "R3 ready after drop", {31'h0, rxReady}, 32'h1);
    expectReg(10'h004, 32'h0, "R3 data port only");
    busWrite(10'h00C, 32'h0000_0004);
    offerRx(8'h97, 1);
    expectReg(10'h000, 32'h0000_00C0, "R3 status rx only");

    // R4 store without interrupt, R2 stall
    busWrite(10'h00C, 32'h0000_2004);
    offerRx(8'h5A, 1);
    check(rxReady === 1'b0, "R2 ready low when full", {31'h0, rxReady}, 32'h0);
    check(irq === 1'b0, "R4 no irq without enable", {31'h0, irq}, 32'h0);
    expectReg(10'h000, 32'h0000_00E0, "R4 status full");
    offerRx(8'h33, 3);
    check(rxReady === 1'b0, "R2 still stalled", {31'h0, rxReady}, 32'h0);
    expectReg(10'h004, 32'h0000_005A, "R2 R5 data kept");
    check(rxReady === 1'b1, "R5 ready after read", {31'h0, rxReady}, 32'h1);
    expectReg(10'h000, 32'h0000_00C0, "R5 status cleared");

    // R4 interrupt on receive, R5 interrupt clear on read
    busWrite(10'h00C, 32'h0000_2024);
    offerRx(8'hA7, 1);
    check(irq === 1'b1, "R4 irq on receive", {31'h0, irq}, 32'h1);
    expectReg(10'h004, 32'h0000_00A7, "R5 read value");
    check(irq === 1'b0, "R5 irq cleared", {31'h0, irq}, 32'h0);

    // R9 late enable raises interrupt
    busWrite(10'h00C, 32'h0000_2004);
    offerRx(8'h11, 1);
    check(irq === 1'b0, "R9 no irq before enable", {31'h0, irq}, 32'h0);
    busWrite(10'h00C, 32'h0000_2024);
    check(irq === 1'b1, "R9 irq on cr1 write", {31'h0, irq}, 32'h1);

    // R7 status write clearing bit 5 drops interrupt
    busWrite(10'h000, 32'h0);
    check(irq === 1'b0, "R7 irq dropped", {31'h0, irq}, 32'h0);
    check(rxReady === 1'b1, "R7 ready", {31'h0, rxReady}, 32'h1);
    expectReg(10'h000, 32'h0000_0080, "R6 load forces bit7");

    // R6 load vs AND
    busWrite(10'h000, 32'h0000_03FF);
    expectReg(10'h000, 32'h0000_03FF, "R6 load 3FF");
    check(rxReady === 1'b0, "R2 flag set by write", {31'h0, rxReady}, 32'h0);
    busWrite(10'h000, 32'hFFFF_FFBF);
    expectReg(10'h000, 32'h0000_03BF, "R6 and mask");
    busWrite(10'h000, 32'h0000_0001);
    expectReg(10'h000, 32'h0000_0081, "R6 load small");

    // R8 transmit and threshold
    sendTx(32'h0000_1234);
    expectReg(10'h000, 32'h0000_00C1, "R8 tc set");
    check(txValid === 1'b0, "R8 pulse one cycle", {31'h0, txValid}, 32'h0);
    busWrite(10'h000, 32'h0);
    sendTx(32'h0000_F000);
    check(txValid === 1'b0, "R8 no pulse at limit", {31'h0, txValid}, 32'h0);
    expectReg(10'h000, 32'h0000_0080, "R8 status unchanged");
    sendTx(32'h0000_EFFF);
    sendTx(32'h0000_0042);
    expectReg(10'h000, 32'h0000_00C0, "R8 tc after limit-1");

    // R10 storage registers
    busWrite(10'h008, 32'hDEAD_BEEF);
    busWrite(10'h010, 32'h1357_9BDF);
    busWrite(10'h014, 32'h0246_8ACE);
    busWrite(10'h018, 32'hA5A5_5A5A);
    expectReg(10'h008, 32'hDEAD_BEEF, "R10 brr");
    expectReg(10'h010, 32'h1357_9BDF, "R10 cr2");
    expectReg(10'h014, 32'h0246_8ACE, "R10 cr3");
    expectReg(10'h018, 32'hA5A5_5A5A, "R10 gtpr");

    // R11 undecoded offsets
    busWrite(10'h01C, 32'hFFFF_FFFF);
    busWrite(10'h3FC, 32'hFFFF_FFFF);
    busWrite(10'h002, 32'h0);
    expectReg(10'h01C, 32'h0, "R11 read 01C");
    expectReg(10'h3FC, 32'h0, "R11 read 3FC");
    expectReg(10'h000, 32'h0000_00C0, "R11 status untouched");
    expectReg(10'h00C, 32'h0000_2024, "R11 cr1 untouched");
    expectReg(10'h008, 32'hDEAD_BEEF, "R11 brr untouched");

    repeat (3) @(negedge clk);
    check(txExp.size() == 0, "R8 queue drained", txExp.size(), 32'h0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule